// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block turns one 32-bit register write into a clause-22 management transaction on an MDC/MDIO pair. Software composes the whole frame in a single word. The start code, opcode, PHY address, register address, turnaround and data already sit in the positions they occupy on the wire. The engine prepends a run of preamble ones, shifts the word out MSB first on a divided MDC clock and, for a read, returns the PHY's 16 data bits in the low half of the same register.

Software first enables the management port in the control register and picks an MDC ratio in the configuration register. It polls the idle bit in the status register, writes the frame word, and polls the idle bit again. For a read, it then reads the frame register back. Writes that reach the frame register while a transaction is running, or while the port is disabled, are dropped.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: In the frame register, bits 29:28 equal to 10 mark a read; any other opcode value is sent as a write. For a write, the register keeps the written word unchanged through and after the transaction.
- R2: A frame drives MDIO (enable high) with 32 ones, then with frame bits 31 down to 0, one bit per MDC period. Each bit is stable across the MDC rising edge.
- R3: On a read, the output enable drops from the bit that carries frame bit 16 (the second turnaround bit) and stays low until the frame ends.
- R4: On a read, MDIO input is sampled at each of the last 16 MDC rising edges into frame bits 15 down to 0, MSB first. Bits 31:16 keep their written value.
- R5: A read with no PHY answering (input held high) returns 0xFFFF in bits 15:0.
- R6: Status register (address 2) bit 2 reads 1 when idle. It reads 0 from the cycle after a frame write is accepted until the last MDC period ends. MDC is low and MDIO is released while idle.
- R7: A frame-register write while a transaction is running is ignored: the running frame and its result are unaffected.
- R8: Control register (address 0) bit 4 enables the port. With it clear, a frame write does not change the frame register (address 3) and produces no MDC activity.
- R9: Configuration register (address 1) bits 1:0 select the MDC period in clock cycles: 0 gives 8, 1 gives 16, 2 gives 48, 3 gives 64. MDC is low for the first half of each period and high for the second.
- R10: The MDC ratio is taken when a frame starts. A configuration write during a frame takes effect only from the next frame.
- R11: After reset, the control, configuration and frame registers read 0, the status register reads 0x4, MDC is 0 and the output enable is 0.
- R12: The control register reads back only bit 4, and the configuration register reads back only bits 1:0. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 configuration, 2 status, 3 frame |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the pad |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least one clock edge.
- Every entry of the ratio table is even and at least 4, so MDC stays high for two or more cycles.
- The PHY changes MDIO only after an MDC falling edge.
- A write strobe lasts one cycle.

The bench's PHY model follows these rules. It updates its input only on MDC falling edges and pulls the line high whenever it is not returning data. Every register access is a single-cycle strobe applied on the falling clock edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_CFG   = 2'd1,
      REG_STAT  = 2'd2,
      REG_FRAME = 2'd3
   } mdio_reg_e;

   localparam int unsigned WORD_W        = 32;
   localparam int unsigned CTRL_EN_BIT   = 4;
   localparam int unsigned STAT_IDLE_BIT = 2;
   localparam int unsigned OPC_MSB       = 29;
   localparam int unsigned OPC_LSB       = 28;
   localparam logic [1:0]  OPC_READ      = 2'b10;
   localparam int unsigned TA_RELEASE    = 16;
   localparam int unsigned DATA_W        = 16;

   typedef struct packed {
      logic [1:0]  start_code;
      logic [1:0]  opcode;
      logic [4:0]  phy_addr;
      logic [4:0]  reg_addr;
      logic [1:0]  turnaround;
      logic [15:0] data;
   } mdio_frame_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int unsigned SEL_W = 2,
   parameter int unsigned DIV_TABLE [2**SEL_W] = '{8, 16, 48, 64}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] sel,
   input  logic             run,
   output logic             mdc,
   output logic             rise_tick,
   output logic             bit_end
);

   localparam int unsigned NUM_SEL = 2**SEL_W;

   function automatic int unsigned max_div();
      int unsigned m = 0;
      for (int i = 0; i < NUM_SEL; i++) begin
         if (DIV_TABLE[i] > m) m = DIV_TABLE[i];
      end
      return m;
   endfunction

   localparam int unsigned MAX_DIV = max_div();
   localparam int unsigned CNT_W   = $clog2(MAX_DIV);

   logic [CNT_W-1:0] tab_half [NUM_SEL];
   logic [CNT_W-1:0] tab_last [NUM_SEL];

   for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_ratio
      if (DIV_TABLE[gi] < 4 || (DIV_TABLE[gi] % 2) != 0) begin : g_bad_ratio
         $error("mdio_mdc_gen: every ratio must be even and at least 4");
      end
      assign tab_half[gi] = CNT_W'(DIV_TABLE[gi] / 2 - 1);
      assign tab_last[gi] = CNT_W'(DIV_TABLE[gi] - 1);
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_q;
   logic [CNT_W-1:0] last_q;
   logic             mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= tab_half[0];
         last_q <= tab_last[0];
         mdc_q  <= 1'b0;
      end else if (start) begin
         cnt_q  <= '0;
         half_q <= tab_half[sel];
         last_q <= tab_last[sel];
         mdc_q  <= 1'b0;
      end else if (run) begin
         if (cnt_q == last_q) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == half_q) mdc_q <= 1'b1;
         end
      end else begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end
   end

   assign mdc       = mdc_q;
   assign rise_tick = run && (cnt_q == half_q);
   assign bit_end   = run && (cnt_q == last_q);

   // MDC high phase lasts at least two cycles (R9)
   assert_mdc_high_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc_q) |=> mdc_q);

   // ratio is frozen for the whole frame (R10)
   assert_ratio_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> ($stable(last_q) && $stable(half_q)));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              rise_tick,
   input  logic              bit_end,
   input  logic              mdio_in,
   output logic              busy,
   output logic [WORD_W-1:0] frame,
   output logic              mdio_out,
   output logic              mdio_oe
);

   localparam int unsigned TOTAL = PRE_LEN + WORD_W;
   localparam int unsigned IDX_W = $clog2(TOTAL);

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("mdio_frame_seq: preamble must be at least one bit");
   end

   logic [IDX_W-1:0]  idx_q;
   logic              busy_q;
   logic [WORD_W-1:0] frame_q;

   logic              in_pre;
   logic [IDX_W-1:0]  wire_pos;
   logic [WORD_W-1:0] pos_mask;
   logic              is_read;
   logic              in_data;
   logic              released;

   assign in_pre   = idx_q < IDX_W'(PRE_LEN);
   assign wire_pos = IDX_W'(TOTAL - 1) - idx_q;
   assign pos_mask = WORD_W'(1) << wire_pos;
   assign is_read  = frame_q[OPC_MSB:OPC_LSB] == OPC_READ;
   assign in_data  = is_read && !in_pre && (wire_pos < IDX_W'(DATA_W));
   assign released = is_read && !in_pre && (wire_pos <= IDX_W'(TA_RELEASE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         busy_q  <= 1'b0;
         frame_q <= '0;
      end else if (load) begin
         idx_q   <= '0;
         busy_q  <= 1'b1;
         frame_q <= load_word;
      end else if (busy_q) begin
         if (rise_tick && in_data) begin
            frame_q <= mdio_in ? (frame_q | pos_mask) : (frame_q & ~pos_mask);
         end
         if (bit_end) begin
            if (idx_q == IDX_W'(TOTAL - 1)) begin
               idx_q  <= '0;
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign frame    = frame_q;
   assign mdio_out = !busy_q || in_pre || ((frame_q & pos_mask) != '0);
   assign mdio_oe  = busy_q && !released;

   // once released on a read, MDIO stays released until the frame ends (R3)
   assert_release_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$past(mdio_oe)) |-> !mdio_oe);

   // header half of the word never changes while a frame runs (R4, R7)
   assert_header_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> $stable(frame_q[WORD_W-1:DATA_W]));

   // a write frame leaves the whole word untouched (R1)
   assert_write_word_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !is_read) |-> $stable(frame_q));

   // the first bit after a load is a driven preamble one (R2)
   assert_preamble_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (mdio_oe && mdio_out));

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned MDC_SEL_W     = 2,
   parameter int unsigned MDC_DIVS [2**MDC_SEL_W] = '{8, 16, 48, 64},
   parameter int unsigned PREAMBLE_BITS = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_out,
   output logic        mdio_oe,
   input  logic        mdio_in
);

   if (MDC_SEL_W < 1 || MDC_SEL_W > 4) begin : g_bad_sel
      $error("mdio_mgmt_engine: ratio select width must be 1 to 4");
   end

   mdio_reg_e             addr_e;
   logic                  port_en_q;
   logic [MDC_SEL_W-1:0]  div_sel_q;
   logic                  busy;
   logic [WORD_W-1:0]     frame;
   logic                  start;
   logic                  rise_tick;
   logic                  bit_end;
   logic                  idle;

   assign addr_e = mdio_reg_e'(reg_addr);
   assign start  = reg_wr && (addr_e == REG_FRAME) && port_en_q && !busy;
   assign idle   = !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         port_en_q <= 1'b0;
         div_sel_q <= '0;
      end else if (reg_wr) begin
         if (addr_e == REG_CTRL) port_en_q <= reg_wdata[CTRL_EN_BIT];
         if (addr_e == REG_CFG)  div_sel_q <= reg_wdata[MDC_SEL_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (addr_e)
         REG_CTRL:  reg_rdata[CTRL_EN_BIT]     = port_en_q;
         REG_CFG:   reg_rdata[MDC_SEL_W-1:0]   = div_sel_q;
         REG_STAT:  reg_rdata[STAT_IDLE_BIT]   = idle;
         REG_FRAME: reg_rdata                  = frame;
         default:   reg_rdata                  = '0;
      endcase
   end

   mdio_mdc_gen #(
      .SEL_W     (MDC_SEL_W),
      .DIV_TABLE (MDC_DIVS)
   ) i_mdc_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .sel       (div_sel_q),
      .run       (busy),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .bit_end   (bit_end)
   );

   mdio_frame_seq #(
      .PRE_LEN (PREAMBLE_BITS)
   ) i_frame_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .load_word (reg_wdata),
      .rise_tick (rise_tick),
      .bit_end   (bit_end),
      .mdio_in   (mdio_in),
      .busy      (busy),
      .frame     (frame),
      .mdio_out  (mdio_out),
      .mdio_oe   (mdio_oe)
   );

   // a frame only starts while the port is enabled (R8)
   assert_start_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(port_en_q));

   // idle means a quiet bus: MDC low and MDIO released (R6)
   assert_idle_bus_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!mdio_oe && !mdc));

   // MDC toggles only inside a frame (R6)
   assert_mdc_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> busy);

endmodule

// File: tb/test_mdio_mgmt_engine.sv
`timescale 1ns/1ps
module test_mdio_mgmt_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc;
   logic        mdio_out;
   logic        mdio_oe;
   logic        mdio_in = 1'b1;

   always #4 clk = ~clk;

   mdio_mgmt_engine i_mdio_mgmt_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .mdc       (mdc),
      .mdio_out  (mdio_out),
      .mdio_oe   (mdio_oe),
      .mdio_in   (mdio_in)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // ---- PHY model ----
   int          rise_cnt = 0;
   int          frame_base = 0;
   logic [63:0] cap_bits = '0;
   logic [63:0] cap_oe = '0;
   logic [15:0] phy_reply = '0;
   bit          phy_present = 1'b0;
   time         last_rise = 0;
   time         prev_rise = 0;
   time         last_fall = 0;

   always @(posedge mdc) begin
      cap_bits  <= {cap_bits[62:0], mdio_out};
      cap_oe    <= {cap_oe[62:0], mdio_oe};
      rise_cnt  <= rise_cnt + 1;
      prev_rise <= last_rise;
      last_rise <= $time;
   end

   always @(negedge mdc) begin
      int k;
      k = rise_cnt - frame_base;
      last_fall <= $time;
      if (phy_present && k >= 48 && k < 64) mdio_in <= phy_reply[63-k];
      else mdio_in <= 1'b1;
   end

   // ---- helpers ----
   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         reg_read(2'd2, s);
         if (s[2]) break;
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                      input logic [4:0] ra, input logic [15:0] d);
      return {2'b01, op, phy, ra, 2'b10, d};
   endfunction

   typedef struct packed {
      logic [31:0] word;
      logic [15:0] reply;
      logic        present;
      logic [1:0]  sel;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{mk(2'b01, 5'd1,  5'd0,  16'h1140), 16'h0000, 1'b1, 2'd0},
      '{mk(2'b10, 5'd1,  5'd2,  16'h0000), 16'h0141, 1'b1, 2'd0},
      '{mk(2'b10, 5'd31, 5'd1,  16'h0000), 16'h796D, 1'b1, 2'd1},
      '{mk(2'b10, 5'd7,  5'd1,  16'h0000), 16'h1234, 1'b0, 2'd0},
      '{mk(2'b01, 5'd31, 5'd31, 16'hFFFF), 16'h0000, 1'b1, 2'd1},
      '{mk(2'b10, 5'd0,  5'd3,  16'h0000), 16'h0000, 1'b1, 2'd0},
      '{mk(2'b01, 5'd16, 5'd5,  16'h0000), 16'h0000, 1'b1, 2'd0}
   };

   // expected masks from R2/R3: 47 driven bits then 17 released on a read
   localparam logic [63:0] READ_OE = {{47{1'b1}}, {17{1'b0}}};

   task automatic run_frame(input logic [31:0] w, input logic [15:0] rep,
                            input bit present, input string tag);
      logic [31:0] s;
      logic [31:0] rb;
      logic [31:0] exp_rb;
      logic [63:0] exp_oe;
      bit rd;
      rd          = (w[29:28] == 2'b10);
      phy_reply   = rep;
      phy_present = present;
      frame_base  = rise_cnt;
      reg_write(2'd3, w);
      reg_read(2'd2, s);
      check("R6", {tag, " idle low after start"}, 64'(s[2]), 64'd0);
      wait_idle();
      exp_rb = rd ? {w[31:16], present ? rep : 16'hFFFF} : w;
      exp_oe = rd ? READ_OE : '1;
      reg_read(2'd3, rb);
      check(rd ? (present ? "R4" : "R5") : "R1", {tag, " readback"}, 64'(rb), 64'(exp_rb));
      check(rd ? "R3" : "R2", {tag, " enable pattern"}, cap_oe, exp_oe);
      check("R2", {tag, " wire bits"}, cap_bits & exp_oe, {32'hFFFF_FFFF, w} & exp_oe);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual expired expected finish");
         finish_up();
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] prev_frame;
      int r0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      reg_read(2'd0, d); check("R11", "ctrl reset", 64'(d), 64'h0);
      reg_read(2'd1, d); check("R11", "cfg reset", 64'(d), 64'h0);
      reg_read(2'd2, d); check("R11", "status reset", 64'(d), 64'h4);
      reg_read(2'd3, d); check("R11", "frame reset", 64'(d), 64'h0);
      check("R11", "mdc reset", 64'(mdc), 64'd0);
      check("R11", "oe reset", 64'(mdio_oe), 64'd0);

      // R8 disabled port ignores frame writes
      r0 = rise_cnt;
      reg_write(2'd3, mk(2'b01, 5'd2, 5'd4, 16'hBEEF));
      repeat (100) @(negedge clk);
      reg_read(2'd3, d); check("R8", "frame unchanged when disabled", 64'(d), 64'h0);
      check("R8", "no mdc when disabled", 64'(rise_cnt - r0), 64'd0);
      reg_read(2'd2, d); check("R8", "idle when disabled", 64'(d), 64'h4);

      // R12 readback of implemented bits, status read-only
      reg_write(2'd0, 32'hFFFF_FFFF);
      reg_read(2'd0, d); check("R12", "ctrl readback", 64'(d), 64'h10);
      reg_write(2'd1, 32'hFFFF_FFFF);
      reg_read(2'd1, d); check("R12", "cfg readback", 64'(d), 64'h3);
      reg_write(2'd2, 32'h0);
      reg_read(2'd2, d); check("R12", "status write ignored", 64'(d), 64'h4);

      // table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         reg_write(2'd1, 32'(VECS[v].sel));
         run_frame(VECS[v].word, VECS[v].reply, VECS[v].present, $sformatf("vec%0d", v));
         check("R9", $sformatf("vec%0d period", v), 64'((last_rise - prev_rise) / 8),
               (VECS[v].sel == 2'd0) ? 64'd8 : 64'd16);
      end

      // R9 larger ratios, including high-phase length
      reg_write(2'd1, 32'd2);
      run_frame(mk(2'b01, 5'd3, 5'd9, 16'h0F0F), 16'h0, 1'b1, "div48");
      check("R9", "div48 period", 64'((last_rise - prev_rise) / 8), 64'd48);
      check("R9", "div48 high time", 64'((last_fall - last_rise) / 8), 64'd24);
      reg_write(2'd1, 32'd3);
      run_frame(mk(2'b10, 5'd3, 5'd9, 16'h0), 16'hC3A5, 1'b1, "div64");
      check("R9", "div64 period", 64'((last_rise - prev_rise) / 8), 64'd64);
      check("R9", "div64 high time", 64'((last_fall - last_rise) / 8), 64'd32);

      // R10 ratio change mid-frame applies only to the next frame
      reg_write(2'd1, 32'd0);
      phy_present = 1'b1;
      frame_base  = rise_cnt;
      reg_write(2'd3, mk(2'b01, 5'd4, 5'd1, 16'h5555));
      repeat (100) @(negedge clk);
      reg_write(2'd1, 32'd3);
      wait_idle();
      check("R10", "period kept mid-frame", 64'((last_rise - prev_rise) / 8), 64'd8);
      run_frame(mk(2'b01, 5'd4, 5'd1, 16'hAAAA), 16'h0, 1'b1, "after cfg");
      check("R10", "new ratio next frame", 64'((last_rise - prev_rise) / 8), 64'd64);

      // R7 write while busy is ignored
      reg_write(2'd1, 32'd0);
      phy_reply   = 16'hA5C3;
      phy_present = 1'b1;
      frame_base  = rise_cnt;
      reg_write(2'd3, mk(2'b10, 5'd9, 5'd17, 16'h0));
      repeat (200) @(negedge clk);
      reg_write(2'd3, mk(2'b01, 5'd1, 5'd1, 16'h7777));
      wait_idle();
      reg_read(2'd3, d);
      check("R7", "busy write ignored readback", 64'(d), 64'({mk(2'b10, 5'd9, 5'd17, 16'h0) >> 16, 16'hA5C3}));
      check("R7", "busy write kept read pattern", cap_oe, READ_OE);

      // R8 disabling the port again blocks new frames
      reg_read(2'd3, prev_frame);
      reg_write(2'd0, 32'h0);
      r0 = rise_cnt;
      reg_write(2'd3, mk(2'b01, 5'd0, 5'd0, 16'h0001));
      repeat (50) @(negedge clk);
      reg_read(2'd3, d); check("R8", "frame kept after disable", 64'(d), 64'(prev_frame));
      check("R8", "no mdc after disable", 64'(rise_cnt - r0), 64'd0);
      check("R6", "mdc low idle", 64'(mdc), 64'd0);

      done = 1'b1;
      finish_up();
   end

endmodule